// File: doc/BRIEF.md
# Quadrature Encoder Counter Channel

This block is one channel of an incremental encoder counter. It takes the two phase inputs and the index input of a rotary or linear encoder, passes them through a two-flop synchronizer, and decodes the phase edges into up and down steps of a 25-bit position count. Three resolutions are available: one, two or four steps per full phase cycle.

A small write port reaches four registers: the resolution mode, an I/O control word, a 24-bit preset and a direct 24-bit count load. Each of the three flag outputs changes level when its event occurs. Carry changes on an upward wrap. Borrow changes on a downward wrap. Compare changes when a step brings the count onto the preset. An index pulse of the selected polarity can copy the preset into the count, which re-references the position once per revolution.

Top module: `qenc_channel`

## Requirements
- R1: After reset the count is 0, the preset is 0, all three flag outputs are 0, the mode is 1x and the I/O control word is 0.
- R2: A write with wr_sel=3 loads wr_data[23:0] into count bits 23..0 and clears count bit 24. The new value appears after the write clock edge.
- R3: While I/O control bit 0 (phase enable) is 0, phase input edges leave the count unchanged.
- R4: Mode wr_data[4:3]=3 (written value 0x18) selects 4x. Every single edge of A or B steps the count. An A edge counts up when A differs from B after the edge. A B edge counts up when A equals B after the edge. All other edges count down.
- R5: Mode wr_data[4:3]=2 (value 0x10) selects 2x. Both edges of A step the count, using the A-edge direction rule of R4. B edges do not step.
- R6: Mode wr_data[4:3]=1 (value 0x08) selects 1x. Only a rising edge of A steps the count. It counts up when B is 0 and down when B is 1.
- R7: A down step from 0 wraps the count to 0x1FFFFFF and inverts borrow_out.
- R8: An up step from 0x1FFFFFF wraps the count to 0 and inverts carry_out.
- R9: compare_out inverts when a count step produces a value equal to the preset (written with wr_sel=2, bits 23..0). A direct count load does not invert it.
- R10: When I/O control bit 2 (index enable) and bit 1 (preset on index) are both 1, an index event copies the preset into the count. With bit 3 at 0 the event is a falling edge of idx_in. With bit 3 at 1 it is a rising edge. An edge in the other direction does nothing.
- R11: When either I/O control bit 1 or bit 2 is 0, index edges leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 1 | Encoder phase A |
| b_in | input | 1 | Encoder phase B |
| idx_in | input | 1 | Encoder index |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 I/O control, 2 preset, 3 count load |
| wr_data | input | 24 | Write data |
| count_out | output | 25 | Position count |
| carry_out | output | 1 | Level that inverts on each upward wrap |
| borrow_out | output | 1 | Level that inverts on each downward wrap |
| compare_out | output | 1 | Level that inverts on each step onto the preset |

## Verification
The bench runs forward and reverse phase cycles in each of the three resolutions and computes the expected count from the step rate of that resolution. A wrong direction rule or a wrong edge selection shows up there as a count that is off by a multiple of the phase-cycle count. Both wraps are reached by counting down from 0 and then back up. A design that lost bit 24, or that inverted the wrong flag, would show 0xFFFFFF or a stuck flag. The compare flag is driven onto, past and back onto the preset, and a direct load onto the preset checks that loading does not invert it. Index pulses are sent with both polarities and with each enable bit cleared in turn, so a design that loads on the wrong edge, or ignores a gate bit, ends with the wrong count.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    RES_OFF = 2'b00,
    RES_X1  = 2'b01,
    RES_X2  = 2'b10,
    RES_X4  = 2'b11
  } res_e;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_IOCTL  = 2'd1;
  localparam logic [1:0] SEL_PRESET = 2'd2;
  localparam logic [1:0] SEL_COUNT  = 2'd3;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_in[i];
        s2_q <= s1_q;
      end
    end
    assign q_out[i] = s2_q;
  end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  res_e res,
  input  logic en,
  output logic step_up,
  output logic step_dn
);
  logic a_prev_q, b_prev_q;
  logic a_edge, b_edge, a_dir_up, b_dir_up;

  assign a_edge   = a ^ a_prev_q;
  assign b_edge   = b ^ b_prev_q;
  assign a_dir_up = a ^ b;
  assign b_dir_up = ~(a ^ b);

  always_comb begin
    step_up = 1'b0;
    step_dn = 1'b0;
    if (en && !(a_edge && b_edge)) begin
      case (res)
        RES_X1: if (a_edge && a) begin
          step_up = ~b;
          step_dn = b;
        end
        RES_X2: if (a_edge) begin
          step_up = a_dir_up;
          step_dn = ~a_dir_up;
        end
        RES_X4: begin
          if (a_edge) begin
            step_up = a_dir_up;
            step_dn = ~a_dir_up;
          end else if (b_edge) begin
            step_up = b_dir_up;
            step_dn = ~b_dir_up;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a;
      b_prev_q <= b;
    end
  end

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  a_r6_x1_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (res == RES_X1 && (step_up || step_dn)) |-> (a && !$past(a)));
endmodule

// File: rtl/qenc_index.sv
module qenc_index (
  input  logic clk,
  input  logic rst_n,
  input  logic idx,
  input  logic idx_en,
  input  logic pol_high,
  output logic idx_evt
);
  logic idx_prev_q, act_now, act_prev;

  assign act_now  = pol_high ? idx : ~idx;
  assign act_prev = pol_high ? idx_prev_q : ~idx_prev_q;
  assign idx_evt  = idx_en & act_now & ~act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_prev_q <= 1'b0;
    else        idx_prev_q <= idx;
  end
endmodule

// File: rtl/qenc_core.sv
module qenc_core #(
  parameter int CNT_W  = 25,
  parameter int LOAD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_up,
  input  logic              step_dn,
  input  logic              idx_load,
  input  logic              wr_count,
  input  logic              wr_preset,
  input  logic [LOAD_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              carry,
  output logic              borrow,
  output logic              compare
);
  localparam int PAD_W = CNT_W - LOAD_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_n, pre_q, pre_n, cnt_inc, cnt_dec;
  logic car_q, car_n, bor_q, bor_n, cmp_q, cmp_n;

  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_dec = cnt_q - 1'b1;

  always_comb begin
    cnt_n = cnt_q;
    pre_n = pre_q;
    car_n = car_q;
    bor_n = bor_q;
    cmp_n = cmp_q;
    if (wr_count) begin
      cnt_n = {{PAD_W{1'b0}}, wr_data};
    end else if (idx_load) begin
      cnt_n = pre_q;
    end else if (step_up) begin
      cnt_n = cnt_inc;
      if (cnt_q == CNT_MAX) car_n = ~car_q;
      if (cnt_inc == pre_q) cmp_n = ~cmp_q;
    end else if (step_dn) begin
      cnt_n = cnt_dec;
      if (cnt_q == '0) bor_n = ~bor_q;
      if (cnt_dec == pre_q) cmp_n = ~cmp_q;
    end
    if (wr_preset) pre_n = {{PAD_W{1'b0}}, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      car_q <= 1'b0;
      bor_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      pre_q <= pre_n;
      car_q <= car_n;
      bor_q <= bor_n;
      cmp_q <= cmp_n;
    end
  end

  assign count   = cnt_q;
  assign carry   = car_q;
  assign borrow  = bor_q;
  assign compare = cmp_q;

  a_r2_load_clears_top: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (cnt_q[CNT_W-1] == 1'b0 && cnt_q[LOAD_W-1:0] == $past(wr_data)));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn && !wr_count && !idx_load) |=> $stable(cnt_q));

  a_r8_carry_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (car_q != $past(car_q)) |-> (cnt_q == '0 && $past(cnt_q) == CNT_MAX));

  a_r7_borrow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_q != $past(bor_q)) |-> (cnt_q == CNT_MAX && $past(cnt_q) == '0));

  a_r9_compare_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q != $past(cmp_q)) |-> (cnt_q == $past(pre_q)));
endmodule

// File: rtl/qenc_channel.sv
module qenc_channel
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 25,
  parameter int LOAD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_in,
  input  logic              b_in,
  input  logic              idx_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [LOAD_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_out,
  output logic              carry_out,
  output logic              borrow_out,
  output logic              compare_out
);
  localparam int IOC_W = 4;

  res_e             res_q, res_n;
  logic [IOC_W-1:0] ioc_q, ioc_n;
  logic [2:0]       sync_q;
  logic             step_up, step_dn, idx_evt;

  always_comb begin
    res_n = res_q;
    ioc_n = ioc_q;
    if (wr_en && wr_sel == SEL_MODE)  res_n = res_e'(wr_data[4:3]);
    if (wr_en && wr_sel == SEL_IOCTL) ioc_n = wr_data[IOC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_X1;
      ioc_q <= '0;
    end else begin
      res_q <= res_n;
      ioc_q <= ioc_n;
    end
  end

  qenc_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({idx_in, b_in, a_in}),
    .q_out (sync_q)
  );

  qenc_decode u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (sync_q[0]),
    .b       (sync_q[1]),
    .res     (res_q),
    .en      (ioc_q[0]),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  qenc_index u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (sync_q[2]),
    .idx_en   (ioc_q[2]),
    .pol_high (ioc_q[3]),
    .idx_evt  (idx_evt)
  );

  qenc_core #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .idx_load  (idx_evt & ioc_q[1]),
    .wr_count  (wr_en && wr_sel == SEL_COUNT),
    .wr_preset (wr_en && wr_sel == SEL_PRESET),
    .wr_data   (wr_data),
    .count     (count_out),
    .carry     (carry_out),
    .borrow    (borrow_out),
    .compare   (compare_out)
  );
endmodule

// File: tb/qenc_channel_bench.sv
module qenc_channel_bench;
  localparam int CLK_P = 10;
  localparam logic [24:0] MSK = 25'h1FFFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_in = 1'b0, b_in = 1'b0, idx_in = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [23:0] wr_data = 24'd0;
  logic [24:0] count_out;
  logic carry_out, borrow_out, compare_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  qenc_channel u_qenc_channel (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .idx_in(idx_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_out(count_out), .carry_out(carry_out),
    .borrow_out(borrow_out), .compare_out(compare_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle;
    repeat (5) @(negedge clk);
  endtask

  task automatic set_ab(input logic na, input logic nb);
    @(negedge clk);
    a_in = na; b_in = nb;
    settle();
  endtask

  task automatic set_idx(input logic v);
    @(negedge clk);
    idx_in = v;
    settle();
  endtask

  task automatic fwd_cycle;
    set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
  endtask

  task automatic rev_cycle;
    set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [24:0] exp;
    int mult;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(count_out), 0);
    check("R1 carry", 32'(carry_out), 0);
    check("R1 borrow", 32'(borrow_out), 0);
    check("R1 compare", 32'(compare_out), 0);
    // R3: phase enable clear after reset
    fwd_cycle();
    check("R3 disabled count", 32'(count_out), 0);
    wr(2'd1, 24'h1);
    // Resolution sweep: R6 (1x), R5 (2x), R4 (4x)
    for (int m = 1; m <= 3; m++) begin
      mult = (m == 1) ? 1 : (m == 2) ? 2 : 4;
      wr(2'd0, 24'(m << 3));
      for (int nf = 1; nf <= 3; nf++) begin
        wr(2'd3, 24'd1000);
        for (int k = 0; k < nf; k++) fwd_cycle();
        exp = 25'(1000 + nf * mult);
        check(m == 1 ? "R6 fwd" : m == 2 ? "R5 fwd" : "R4 fwd", 32'(count_out), 32'(exp));
        for (int k = 0; k <= nf; k++) rev_cycle();
        exp = 25'(1000 - mult);
        check(m == 1 ? "R6 rev" : m == 2 ? "R5 rev" : "R4 rev", 32'(count_out), 32'(exp));
      end
    end
    // R3 again in 4x
    wr(2'd1, 24'h0);
    wr(2'd3, 24'd77);
    fwd_cycle();
    check("R3 disabled 4x", 32'(count_out), 77);
    wr(2'd1, 24'h1);
    // Wraps (4x, preset away from wrap values)
    wr(2'd2, 24'h777);
    wr(2'd3, 24'd0);
    set_ab(0, 1);
    check("R7 underflow count", 32'(count_out), 32'(MSK));
    check("R7 borrow", 32'(borrow_out), 1);
    check("R7 carry unchanged", 32'(carry_out), 0);
    set_ab(0, 0);
    check("R8 overflow count", 32'(count_out), 0);
    check("R8 carry", 32'(carry_out), 1);
    wr(2'd3, 24'hABCDEF);
    check("R2 load", 32'(count_out), 32'h0ABCDEF);
    wr(2'd3, 24'd0);
    set_ab(0, 1);
    check("R7 borrow second", 32'(borrow_out), 0);
    wr(2'd3, 24'd5);
    check("R2 top bit cleared", 32'(count_out), 5);
    set_ab(0, 0);
    check("R4 single edge", 32'(count_out), 6);
    // Compare
    wr(2'd2, 24'd10);
    wr(2'd3, 24'd8);
    set_ab(1, 0);
    set_ab(1, 1);
    check("R9 hit count", 32'(count_out), 10);
    check("R9 compare set", 32'(compare_out), 1);
    set_ab(0, 1);
    check("R9 compare past", 32'(compare_out), 1);
    set_ab(1, 1);
    check("R9 compare back", 32'(compare_out), 0);
    set_ab(1, 0);
    set_ab(0, 0);
    wr(2'd3, 24'd10);
    check("R9 load no toggle", 32'(compare_out), 0);
    // Index, negative polarity
    wr(2'd2, 24'h123);
    wr(2'd1, 24'h7);
    set_idx(1);
    check("R10 inactive edge neg", 32'(count_out), 10);
    set_idx(0);
    check("R10 falling load", 32'(count_out), 32'h123);
    // positive polarity
    wr(2'd3, 24'h55);
    wr(2'd1, 24'hF);
    set_idx(1);
    check("R10 rising load", 32'(count_out), 32'h123);
    wr(2'd3, 24'h55);
    set_idx(0);
    check("R10 inactive edge pos", 32'(count_out), 32'h55);
    // Gates
    wr(2'd1, 24'hB);
    wr(2'd3, 24'h66);
    set_idx(1);
    check("R11 index disabled", 32'(count_out), 32'h66);
    set_idx(0);
    wr(2'd1, 24'hD);
    set_idx(1);
    check("R11 preset load off", 32'(count_out), 32'h66);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule